// File: doc/BRIEF.md
# Indirect Register Window

This block gives a host processor access to a bank of internal control registers through only two byte-wide bus locations. Location 0 takes a register index when written and returns a status byte when read. Location 1 is the data port for the register that the index points at. Every access to the bank takes a modelled internal latency. A ready flag in the status byte tells the host when the next data access may be issued.

An active-low interrupt pulls low when the ready flag goes from busy to ready. A host that does not want to poll can wait for the interrupt instead. Reading the status location releases the interrupt.

The host bus is a single-cycle strobe: `bus_cs` is high for one clock, with `bus_we` and `bus_addr` giving direction and location. Read data is registered. It appears on `bus_rdata` after the clock edge that accepts the read, and it holds until the next read.

Top module: `regwin_top`

## Requirements
- R1: After reset, `irq_n` is 1 and `bus_rdata` is 0x00. A status read returns 0x80. Every internal register reads as 0x00 until it is written.
- R2: A write to location 0 stores the written byte as the index and clears ready. A status read in any of the following LAT cycles returns 0x00, and the next status read returns 0x80.
- R3: A status read returns ready in bit 7, with bits 6 to 0 always zero. The byte is driven on `bus_rdata` one cycle after the read strobe.
- R4: A write to location 1 while ready updates the indexed register. A read of location 1 while ready returns that register on `bus_rdata` one cycle after the strobe, and the value holds there until the next read.
- R5: A location-1 access accepted while ready clears ready for exactly LAT cycles.
- R6: A location-1 write made while ready is 0 changes no register. A location-1 read made while ready is 0 starts no access and returns the last latched data value.
- R7: With an index of 37 or above, data reads return 0xFF and data writes change no register.
- R8: `irq_n` goes low on the same clock edge at which ready changes from 0 to 1. It never goes low at any other time.
- R9: A status read drives `irq_n` high on the following edge. If the read falls on the same edge as a ready rise, `irq_n` goes low instead.
- R10: A location-0 write made while ready is 0 restarts the full LAT-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index/status, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Ready interrupt, active low |

## Verification
A bad latency counter shows at once in the count of busy status reads that follow an access. It also shows in the cycle in which `irq_n` falls, so it is visible within LAT+1 cycles. A corrupted index or bank entry, a missed valid bit or a wrong out-of-range decision stays hidden until the register is next read. The cycle-by-cycle reference model compares both outputs on every clock, so the first wrong read byte or interrupt edge is reported in the cycle it appears.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned N_REGS  = 37;
  localparam logic [DW-1:0] OOR_VALUE = 8'hFF;

  typedef enum logic [0:0] {
    SRC_STATUS = 1'b0,
    SRC_DATA   = 1'b1
  } rd_src_e;

  typedef struct packed {
    logic sel_wr;
    logic stat_rd;
    logic dat_wr;
    logic dat_rd;
  } bus_req_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic cs,
  input  logic we,
  input  logic addr,
  output bus_req_t req
);
  always_comb begin
    req.sel_wr  = cs &  we & ~addr;
    req.stat_rd = cs & ~we & ~addr;
    req.dat_wr  = cs &  we &  addr;
    req.dat_rd  = cs & ~we &  addr;
  end
endmodule

// File: rtl/regwin_ready.sv
module regwin_ready #(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic begin_acc,
  output logic ready,
  output logic rise
);
  localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_V = CW'(LAT);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  assign ready = ready_q;
  assign rise  = ~ready_q & (cnt_q == ONE_V) & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      cnt_q   <= '0;
    end else if (restart || (ready_q && begin_acc)) begin
      ready_q <= 1'b0;
      cnt_q   <= LAT_V;
    end else if (!ready_q) begin
      if (cnt_q == ONE_V) begin
        ready_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q - ONE_V;
      end
    end
  end

  a_r10_restart_busy: assert property (@(posedge clk) disable iff (rst)
    restart |=> !ready_q);
  a_r5_access_busy: assert property (@(posedge clk) disable iff (rst)
    (ready_q && begin_acc) |=> !ready_q);
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAT_V);
  a_r8_rise_makes_ready: assert property (@(posedge clk) disable iff (rst)
    rise |=> ready_q);
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic stat_rd,
  output logic irq_n
);
  logic irq_n_q;
  assign irq_n = irq_n_q;

  always_ff @(posedge clk) begin
    if (rst)          irq_n_q <= 1'b1;
    else if (rise)    irq_n_q <= 1'b0;
    else if (stat_rd) irq_n_q <= 1'b1;
  end

  a_r8_fire_on_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !irq_n_q);
  a_r9_release_on_read: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rise) |=> irq_n_q);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!rise && irq_n_q) |=> irq_n_q);
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_REGS = 37,
  parameter logic [DW-1:0] OOR  = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] idx,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata
);
  localparam int unsigned AW = (N_REGS < 2) ? 1 : $clog2(N_REGS);

  logic [DW-1:0] mem [0:N_REGS-1];
  logic [N_REGS-1:0] vld_q;
  logic          in_range;
  logic [AW-1:0] a;
  logic [DW-1:0] rd_q;
  logic          rd_vld_q;
  logic          oor_q;

  assign in_range = (32'(idx) < N_REGS);
  assign a        = in_range ? idx[AW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[a] <= wdata;
    if (rd_en) rd_q <= mem[a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
      oor_q    <= 1'b0;
    end else begin
      if (wr_en && in_range) vld_q[a] <= 1'b1;
      if (rd_en) begin
        rd_vld_q <= vld_q[a];
        oor_q    <= ~in_range;
      end
    end
  end

  assign rdata = oor_q ? OOR : (rd_vld_q ? rd_q : '0);

  a_r7_oor_read_ff: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_range) |=> rdata == OOR);
  a_r6_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n
);
  bus_req_t      req;
  logic          ready;
  logic          rise;
  logic          acc_wr;
  logic          acc_rd;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] stat_q;
  rd_src_e       src_q;
  logic [DW-1:0] bank_rd;

  regwin_decode u_dec (
    .cs(bus_cs), .we(bus_we), .addr(bus_addr), .req(req)
  );

  assign acc_wr = req.dat_wr & ready;
  assign acc_rd = req.dat_rd & ready;

  regwin_ready #(.LAT(LAT)) u_rdy (
    .clk(clk), .rst(rst), .restart(req.sel_wr),
    .begin_acc(acc_wr | acc_rd), .ready(ready), .rise(rise)
  );

  regwin_irq u_irq (
    .clk(clk), .rst(rst), .rise(rise), .stat_rd(req.stat_rd), .irq_n(irq_n)
  );

  regwin_bank #(.DW(DW), .N_REGS(N_REGS), .OOR(OOR_VALUE)) u_bank (
    .clk(clk), .rst(rst), .idx(idx_q), .wr_en(acc_wr), .wdata(bus_wdata),
    .rd_en(acc_rd), .rdata(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      stat_q <= '0;
      src_q  <= SRC_STATUS;
    end else begin
      if (req.sel_wr) idx_q <= bus_wdata;
      if (req.stat_rd) begin
        stat_q <= {ready, {(DW-1){1'b0}}};
        src_q  <= SRC_STATUS;
      end else if (req.dat_rd) begin
        src_q  <= SRC_DATA;
      end
    end
  end

  assign bus_rdata = (src_q == SRC_DATA) ? bank_rd : stat_q;

  a_r3_status_low_bits: assert property (@(posedge clk) disable iff (rst)
    req.stat_rd |=> bus_rdata[DW-2:0] == '0);
  a_r6_busy_read_holds: assert property (@(posedge clk) disable iff (rst)
    (req.dat_rd && !ready) |=> $stable(bank_rd));
  a_r2_index_taken: assert property (@(posedge clk) disable iff (rst)
    req.sel_wr |=> idx_q == $past(bus_wdata));
endmodule

// File: tb/regwin_top_test.sv
module regwin_top_test;
  localparam int LAT = 4;
  localparam int NR  = 37;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, we = 1'b0, a = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic irq_n;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regwin_top #(.LAT(LAT)) uut (
    .clk(clk), .rst(rst), .bus_cs(cs), .bus_we(we), .bus_addr(a),
    .bus_wdata(wd), .bus_rdata(rd), .irq_n(irq_n)
  );

  // behavioural reference model
  int m_regs [NR];
  int m_ready, m_cnt, m_sel, m_last, m_stat, m_src, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_regs[i]) m_regs[i] = 0;
      m_ready = 1; m_cnt = 0; m_sel = 0; m_last = 0;
      m_stat = 0; m_src = 0; m_irq = 1;
    end else begin
      int nready, ncnt, rise;
      nready = m_ready; ncnt = m_cnt; rise = 0;
      if (cs && !we && !a) begin m_stat = m_ready ? 8'h80 : 0; m_src = 0; end
      if (cs && !we && a) m_src = 1;
      if (cs && we && !a) begin
        m_sel = wd; nready = 0; ncnt = LAT;
      end else if (!m_ready) begin
        if (m_cnt == 1) begin nready = 1; rise = 1; end
        else ncnt = m_cnt - 1;
      end else if (cs && a) begin
        if (we) begin
          if (m_sel < NR) m_regs[m_sel] = wd;
        end else begin
          m_last = (m_sel < NR) ? m_regs[m_sel] : 8'hFF;
        end
        nready = 0; ncnt = LAT;
      end
      if (rise) m_irq = 0;
      else if (cs && !we && !a) m_irq = 1;
      m_ready = nready; m_cnt = ncnt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("model rdata", {24'd0, rd}, m_src ? m_last : m_stat);
    chk("model irq_n", {31'd0, irq_n}, m_irq);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic strobe(logic ad, logic w, logic [7:0] d);
    cs = 1; a = ad; we = w; wd = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_count(output int n);
    n = 0;
    strobe(0, 0, 0);
    while (!rd[7] && n < 50) begin n++; strobe(0, 0, 0); end
  endtask

  task automatic poll();
    int n;
    busy_count(n);
  endtask

  task automatic rd_reg(int idx, output logic [7:0] v);
    strobe(0, 1, 8'(idx)); poll();
    strobe(1, 0, 0); v = rd; poll();
  endtask

  task automatic wr_reg(int idx, logic [7:0] v);
    strobe(0, 1, 8'(idx)); poll();
    strobe(1, 1, v); poll();
  endtask

  initial begin
    logic [7:0] v, v1;
    int n;
    idle(3);
    rst = 0;
    idle(1);
    chk("R1 rdata after reset", {24'd0, rd}, 8'h00);
    chk("R1 irq_n after reset", {31'd0, irq_n}, 1);
    strobe(0, 0, 0);
    chk("R1 status after reset", {24'd0, rd}, 8'h80);
    chk("R3 low status bits", {25'd0, rd[6:0]}, 0);
    rd_reg(5, v);  chk("R1 unwritten reg 5", {24'd0, v}, 8'h00);
    rd_reg(36, v); chk("R1 unwritten reg 36", {24'd0, v}, 8'h00);

    // R4 writes and readback
    for (int i = 0; i < NR; i += 7) wr_reg(i, 8'(i * 7 + 3));
    wr_reg(36, 8'hC3);
    for (int i = 0; i < NR; i += 7) begin
      rd_reg(i, v); chk("R4 readback", {24'd0, v}, i * 7 + 3);
    end
    rd_reg(36, v); chk("R4 readback reg 36", {24'd0, v}, 8'hC3);
    idle(3); chk("R4 read data holds", {24'd0, rd}, 8'h80);

    // R2 busy after index write
    strobe(0, 1, 8'd7);
    busy_count(n); chk("R2 busy status reads", n, LAT);
    // R10 restart while busy
    strobe(0, 1, 8'd7); idle(2); strobe(0, 1, 8'd14);
    busy_count(n); chk("R10 restarted latency", n, LAT);
    // R5 busy after data access
    strobe(1, 1, 8'h66);
    busy_count(n); chk("R5 busy after data write", n, LAT);
    rd_reg(14, v); chk("R5 write landed", {24'd0, v}, 8'h66);

    // R6 access while busy
    strobe(0, 1, 8'd1); poll();
    strobe(1, 0, 0); v1 = rd;
    poll();
    strobe(1, 1, 8'h55);
    strobe(1, 1, 8'hAA);
    strobe(1, 0, 0);
    chk("R6 busy read returns last", {24'd0, rd}, {24'd0, v1});
    poll();
    strobe(1, 0, 0);
    chk("R6 busy write discarded", {24'd0, rd}, 8'h55);
    poll();

    // R7 out of range
    rd_reg(40, v);  chk("R7 read idx 40", {24'd0, v}, 8'hFF);
    wr_reg(37, 8'h12);
    rd_reg(37, v);  chk("R7 read idx 37", {24'd0, v}, 8'hFF);
    rd_reg(255, v); chk("R7 read idx 255", {24'd0, v}, 8'hFF);
    rd_reg(0, v);   chk("R7 reg 0 untouched", {24'd0, v}, 8'h03);

    // R8 / R9 interrupt
    strobe(0, 1, 8'd3);
    idle(LAT - 1);
    chk("R8 irq not before rise", {31'd0, irq_n}, 1);
    idle(1);
    chk("R8 irq low on rise", {31'd0, irq_n}, 0);
    idle(5);
    chk("R8 irq stays low", {31'd0, irq_n}, 0);
    strobe(0, 0, 0);
    chk("R9 status read releases", {31'd0, irq_n}, 1);
    idle(10);
    chk("R8 no second interrupt", {31'd0, irq_n}, 1);
    strobe(0, 1, 8'd3);
    for (int k = 0; k < LAT; k++) strobe(0, 0, 0);
    chk("R9 rise wins over read", {31'd0, irq_n}, 0);
    strobe(0, 0, 0);
    chk("R9 later read releases", {31'd0, irq_n}, 1);
    chk("R3 ready status", {24'd0, rd}, 8'h80);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule